// File: doc/BRIEF.md
# IF-Sampled IQ Demodulator

This block turns a stream of signed ADC samples of an intermediate-frequency RF signal into complex baseband words. The IF is 50 MHz and the ADC samples at 40 MHz, which is four-fifths of the IF. Because of this ratio, each sample is a quarter-turn further on. The input stream therefore repeats a four-step cycle: +I, +Q, -I, -Q.

The block needs no multiplier and no oscillator. A two-bit slot counter records where the stream is in the cycle. Samples in the two negated slots are sign-flipped with saturation. Each in-phase sample is held and then paired with the quadrature sample that follows it, so the block emits one complex word every second clock (20 M words per second). A one-cycle valid pulse and a pair index (0 for the +I/+Q pair, 1 for the -I/-Q pair) go with each word. The result feeds a digital control loop that runs on the same sample clock.

At the start of each RF pulse, a sync strobe re-aligns the slot counter. The sample that arrives together with the strobe is discarded, and the next sample is taken as +I. Until the first strobe after reset, no words are emitted.

Top module: `if_iq_demod`

## Requirements
- R1: While reset is asserted and right after it, outValid is 0, and outI, outQ and outPhase are 0.
- R2: From reset until the first clock edge that samples syncIn high, outValid stays 0 and the data outputs keep their reset values, whatever the samples are.
- R3: After a sync edge, the next sample s0 is +I and the one after it, s1, is +Q. In the cycle after the edge that takes s1, outValid is 1, outI = s0, outQ = s1 and outPhase = 0.
- R4: The third and fourth samples after a sync, s2 and s3, are -I and -Q. In the cycle after the edge that takes s3, outValid is 1, outI = -s2, outQ = -s3 and outPhase = 1. The four-slot cycle then repeats.
- R5: Negation saturates. The most negative code, -2^(WIDTH-1), in a negated slot becomes 2^(WIDTH-1)-1. Every other code x becomes -x exactly.
- R6: After sync and with no further strobe, outValid is a one-cycle pulse on every second cycle and is never high two cycles running.
- R7: A sync at any point of the cycle restarts the slot counter. The sample taken with the strobe is discarded, and outValid is 0 in the cycle after the strobe edge.
- R8: outI, outQ and outPhase change only on cycles where outValid rises. Otherwise they hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock (40 MHz in use) |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | WIDTH | Signed ADC sample, one per clock |
| syncIn | input | 1 | Pulse-start strobe; the next sample is +I |
| outI | output | WIDTH | Signed in-phase part of the complex word |
| outQ | output | WIDTH | Signed quadrature part of the complex word |
| outValid | output | 1 | One-cycle pulse marking a new complex word |
| outPhase | output | 1 | Pair index: 0 from +I/+Q, 1 from -I/-Q |

## Verification
The hardest case to reach from the ports is the most negative code landing in a negated slot, as either the held -I or the direct -Q. Re-syncs that arrive at odd points of the cycle are also hard to reach. The bench uses a 6-bit instance and feeds every ordered pair of codes as consecutive samples, so the most negative code reaches both negated slots many times. Every 37 pairs it inserts a sync step that carries a throw-away sample, which shifts which pairs land in the positive slots and which in the negated ones.

// File: rtl/iq_demod_pkg.sv
package iq_demod_pkg;

  // Position of the current sample in the four-step cycle.
  typedef enum logic [1:0] {
    PH_POS_I = 2'd0,
    PH_POS_Q = 2'd1,
    PH_NEG_I = 2'd2,
    PH_NEG_Q = 2'd3
  } phaseE;

  // Strobes from the control to the datapath for the current sample.
  typedef struct packed {
    logic loadI;    // capture this sample as the in-phase half
    logic emit;     // this sample completes a complex word
    logic negate;   // sample sits in a negated slot
    logic pairIdx;  // 0: +I/+Q pair, 1: -I/-Q pair
  } ctrlStrobeT;

endpackage

// File: rtl/iq_demod_ctrl.sv
module iq_demod_ctrl
  import iq_demod_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  output ctrlStrobeT strobe,
  output logic       validOut
);

  phaseE phaseQ;
  logic  syncedQ;
  logic  validQ;

  // Strobes come straight from the slot counter; a sync step discards its sample.
  always_comb begin
    strobe.loadI   = !syncIn && !phaseQ[0];
    strobe.emit    = !syncIn && phaseQ[0] && syncedQ;
    strobe.negate  = phaseQ[1];
    strobe.pairIdx = phaseQ[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_POS_I;
      syncedQ <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      validQ <= strobe.emit;
      if (syncIn) begin
        phaseQ  <= PH_POS_I;
        syncedQ <= 1'b1;
      end else begin
        phaseQ <= phaseE'(phaseQ + 2'd1);
      end
    end
  end

  assign validOut = validQ;

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ);

  a_r7_sync_restart: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> (phaseQ == PH_POS_I) && !validQ);

  a_r2_quiet_unsynced: assert property (@(posedge clk) disable iff (!rstN)
    !syncedQ |=> !validQ);

  a_r4_slot_advance: assert property (@(posedge clk) disable iff (!rstN)
    !syncIn |=> phaseQ == phaseE'($past(phaseQ) + 2'd1));

endmodule

// File: rtl/iq_demod_path.sv
module iq_demod_path
  import iq_demod_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [WIDTH-1:0] sampleIn,
  input  ctrlStrobeT              strobe,
  output logic signed [WIDTH-1:0] outI,
  output logic signed [WIDTH-1:0] outQ,
  output logic                    outPhase
);

  localparam logic signed [WIDTH-1:0] MIN_CODE = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic signed [WIDTH-1:0] MAX_CODE = {1'b0, {(WIDTH-1){1'b1}}};

  logic signed [WIDTH-1:0] negVal;
  logic signed [WIDTH-1:0] slotVal;
  logic signed [WIDTH-1:0] iHold;

  // Saturating sign flip: the lone code without a positive twin clamps high.
  always_comb begin
    if (sampleIn == MIN_CODE) negVal = MAX_CODE;
    else                      negVal = -sampleIn;
    slotVal = strobe.negate ? negVal : sampleIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iHold    <= '0;
      outI     <= '0;
      outQ     <= '0;
      outPhase <= 1'b0;
    end else begin
      if (strobe.loadI) iHold <= slotVal;
      if (strobe.emit) begin
        outI     <= iHold;
        outQ     <= slotVal;
        outPhase <= strobe.pairIdx;
      end
    end
  end

  a_r5_sat_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadI && strobe.negate && sampleIn == MIN_CODE) |=> iHold == MAX_CODE);

  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> $stable(outI) && $stable(outQ) && $stable(outPhase));

  a_r3_q_direct: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && !strobe.negate) |=> outQ == $past(sampleIn));

endmodule

// File: rtl/if_iq_demod.sv
module if_iq_demod
  import iq_demod_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [WIDTH-1:0] sampleIn,
  input  logic                    syncIn,
  output logic signed [WIDTH-1:0] outI,
  output logic signed [WIDTH-1:0] outQ,
  output logic                    outValid,
  output logic                    outPhase
);

  ctrlStrobeT strobe;

  iq_demod_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncIn   (syncIn),
    .strobe   (strobe),
    .validOut (outValid)
  );

  iq_demod_path #(.WIDTH(WIDTH)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .strobe   (strobe),
    .outI     (outI),
    .outQ     (outQ),
    .outPhase (outPhase)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !outValid || $past(rstN));

endmodule

// File: tb/if_iq_demod_bench.sv
module if_iq_demod_bench;

  localparam int W    = 6;
  localparam int MINV = -(1 << (W - 1));
  localparam int MAXV = (1 << (W - 1)) - 1;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic signed [W-1:0] sampleIn = '0;
  logic                syncIn = 1'b0;
  logic signed [W-1:0] outI, outQ;
  logic                outValid, outPhase;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // Reference state built from the requirements
  int mPhase = 0;
  bit mSynced = 0;
  int mHold = 0;
  bit mValid = 0;
  int eI = 0, eQ = 0, ePh = 0;

  if_iq_demod #(.WIDTH(W)) u_if_iq_demod (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .syncIn(syncIn),
    .outI(outI), .outQ(outQ), .outValid(outValid), .outPhase(outPhase)
  );

  always #5 clk = ~clk;

  function automatic int satNeg(int v);
    return (v == MINV) ? MAXV : -v;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int x, bit sy);
    @(negedge clk);
    sampleIn = W'(x);
    syncIn = sy;
    @(posedge clk);
    #1;
    mValid = 0;
    if (sy) begin
      mSynced = 1;
      mPhase = 0;
    end else begin
      case (mPhase)
        0: mHold = x;
        1: if (mSynced) begin mValid = 1; eI = mHold; eQ = x; ePh = 0; end
        2: mHold = satNeg(x);
        default: if (mSynced) begin mValid = 1; eI = mHold; eQ = satNeg(x); ePh = 1; end
      endcase
      mPhase = (mPhase + 1) % 4;
    end
    check(!mSynced ? "R2 valid" : (sy ? "R7 valid" : "R6 valid"), int'(outValid), int'(mValid));
    check(mValid ? (ePh == 1 ? "R4 outI" : "R3 outI") : "R8 outI", int'(outI), eI);
    check(mValid ? (ePh == 1 ? "R4 outQ" : "R3 outQ") : "R8 outQ", int'(outQ), eQ);
    check(mValid ? "R3 outPhase" : "R8 outPhase", int'(outPhase), ePh);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", int'(outValid), 0);
    check("R1 outI", int'(outI), 0);
    check("R1 outQ", int'(outQ), 0);
    check("R1 outPhase", int'(outPhase), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: samples before any sync never produce a word
    for (int k = 0; k < 12; k++) step(k * 5 - 20, 1'b0);

    // R3/R4 directed
    step(9, 1'b1);
    step(7, 1'b0);
    step(-3, 1'b0);
    check("R3 directed I", int'(outI), 7);
    check("R3 directed Q", int'(outQ), -3);
    step(11, 1'b0);
    step(-12, 1'b0);
    check("R4 directed I", int'(outI), -11);
    check("R4 directed Q", int'(outQ), 12);
    check("R4 directed phase", int'(outPhase), 1);

    // R5 directed: minimum code in both negated slots
    step(1, 1'b0);
    step(2, 1'b0);
    step(MINV, 1'b0);
    step(MINV, 1'b0);
    check("R5 clamp I", int'(outI), MAXV);
    check("R5 clamp Q", int'(outQ), MAXV);

    // R7 directed: sync in the middle of a pair
    step(4, 1'b0);
    step(20, 1'b1);
    check("R7 no word after sync", int'(outValid), 0);
    step(5, 1'b0);
    step(6, 1'b0);
    check("R7 realigned I", int'(outI), 5);
    check("R7 realigned Q", int'(outQ), 6);

    // Sweep over every ordered pair of codes with periodic re-syncs
    for (int a = MINV; a <= MAXV; a++) begin
      for (int b = MINV; b <= MAXV; b++) begin
        if (((a - MINV) * 64 + (b - MINV)) % 37 == 36) step(a, 1'b1);
        step(a, 1'b0);
        step(b, 1'b0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule